// File: doc/BRIEF.md
# Operand Bypass Selection Unit

This block chooses the two source operands for the ALU of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). For each operand it either keeps the value that decode read from the register file, or replaces it with a newer value still moving down the pipeline. There are two replacement values. One is the ALU result of the instruction that has just left execute. The other is the value leaving the memory stage, which is the load data for a load and the carried ALU result for any other instruction.

The unit is purely combinational and sits between the decode/execute pipeline register and the ALU inputs. For each operand it compares the source register name with the destination names of the two older in-flight instructions. A comparison counts only when the source is actually used, the older instruction writes a register, and that register is not register 0. When both older instructions match, the younger one wins.

A load that has just left execute holds an address, not its result, so it is never forwarded from the execute path. Producing the one-cycle stall for that case is the job of a separate unit. Writeback needs no path here, because the register file already passes a same-cycle write through to its read ports. The select code of each operand is also driven out for observation.

Top module: `operand_bypass_unit`

## Requirements
- R1: When neither older instruction matches a source, that operand equals its register-file value and its select code is 2'b00.
- R2: When the instruction just past execute matches a used source, writes a register, has a nonzero destination and is not a load, the operand equals `exm_result` and the select code is 2'b01.
- R3: When only the instruction just past memory matches a used source, writes a register and has a nonzero destination, the operand equals `mwb_data` and the select code is 2'b10.
- R4: When both older instructions qualify for the same source, the execute-side value wins and the select code is 2'b01.
- R5: An older instruction with its write enable low never causes forwarding.
- R6: A destination or source of register 0 never causes forwarding. The operand keeps its register-file value, unless the other producer qualifies on a nonzero name.
- R7: When the instruction just past execute is a load (`exm_is_load` = 1), it is never forwarded. The operand falls back to the memory-stage value if that producer qualifies, otherwise to the register file.
- R8: A source whose use flag is low always selects the register file (2'b00), whatever the names are.
- R9: The two operands are resolved independently. Each applies R1 to R8 using only its own source name, use flag and register-file value.
- R10: A select code is never 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx | input | 5 | Register name of operand A |
| src_a_used | input | 1 | Operand A is read by the instruction |
| rf_a_data | input | 32 | Register-file value read for operand A |
| src_b_idx | input | 5 | Register name of operand B |
| src_b_used | input | 1 | Operand B is read by the instruction |
| rf_b_data | input | 32 | Register-file value read for operand B |
| exm_dst | input | 5 | Destination of the instruction just past execute |
| exm_wen | input | 1 | That instruction writes a register |
| exm_is_load | input | 1 | That instruction is a load |
| exm_result | input | 32 | ALU output of that instruction |
| mwb_dst | input | 5 | Destination of the instruction just past memory |
| mwb_wen | input | 1 | That instruction writes a register |
| mwb_data | input | 32 | Value leaving the memory stage (load data or carried result) |
| opnd_a | output | 32 | Selected operand A |
| opnd_b | output | 32 | Selected operand B |
| sel_a | output | 2 | Select code of operand A: 00 register file, 01 execute result, 10 memory data |
| sel_b | output | 2 | Select code of operand B, same encoding |

## Verification
There is no stored state, so a wrong match, a wrong priority or a wrong load qualification shows at the ports in the same evaluation as the inputs that trigger it. The error appears both as a wrong select code and as a wrong operand value. Names are drawn from a small set so that matches, double matches and register-0 cases occur often in the random phase. Directed vectors cover each qualifying condition on its own.

// File: rtl/byp_pkg.sv
package byp_pkg;

    localparam int DEF_DATA_W = 32;
    localparam int DEF_IDX_W  = 5;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_EXR = 2'b01,
        SEL_MEM = 2'b10
    } opnd_sel_e;

    // A producer qualifies for a source when every gating condition holds.
    function automatic logic producer_qualifies(
        input logic names_equal,
        input logic dst_nonzero,
        input logic writes_reg,
        input logic src_used,
        input logic blocked
    );
        return names_equal & dst_nonzero & writes_reg & src_used & ~blocked;
    endfunction

endpackage

// File: rtl/byp_hit_detect.sv
module byp_hit_detect #(
    parameter int IDX_W       = byp_pkg::DEF_IDX_W,
    parameter bit BLOCK_LOADS = 1'b0
) (
    input  logic [IDX_W-1:0] src_idx,
    input  logic             src_used,
    input  logic [IDX_W-1:0] dst_idx,
    input  logic             dst_wen,
    input  logic             dst_is_load,
    output logic             hit
);
    import byp_pkg::*;

    logic load_block;

    generate
        if (BLOCK_LOADS) begin : g_block
            assign load_block = dst_is_load;
        end else begin : g_pass
            assign load_block = 1'b0;
        end
    endgenerate

    assign hit = producer_qualifies(src_idx == dst_idx,
                                    |dst_idx,
                                    dst_wen,
                                    src_used,
                                    load_block);

    always_comb begin
        // R6
        zero_dst_chk: assert (!(hit && dst_idx == '0));
        // R5
        wen_gate_chk: assert (!(hit && !dst_wen));
    end

endmodule

// File: rtl/byp_priority.sv
module byp_priority (
    input  logic             exm_hit,
    input  logic             mwb_hit,
    output byp_pkg::opnd_sel_e sel
);
    import byp_pkg::*;

    always_comb begin
        if (exm_hit)      sel = SEL_EXR;
        else if (mwb_hit) sel = SEL_MEM;
        else              sel = SEL_RF;
    end

    always_comb begin
        // R4
        younger_wins_chk: assert (!(exm_hit && sel != SEL_EXR));
        // R10
        sel_code_chk: assert (sel != 2'b11);
    end

endmodule

// File: rtl/byp_data_mux.sv
module byp_data_mux #(
    parameter int DATA_W = byp_pkg::DEF_DATA_W
) (
    input  byp_pkg::opnd_sel_e sel,
    input  logic [DATA_W-1:0]  rf_val,
    input  logic [DATA_W-1:0]  exr_val,
    input  logic [DATA_W-1:0]  mem_val,
    output logic [DATA_W-1:0]  out_val
);
    import byp_pkg::*;

    always_comb begin
        unique case (sel)
            SEL_EXR: out_val = exr_val;
            SEL_MEM: out_val = mem_val;
            default: out_val = rf_val;
        endcase
    end

endmodule

// File: rtl/operand_bypass_unit.sv
module operand_bypass_unit #(
    parameter int DATA_W = byp_pkg::DEF_DATA_W,
    parameter int IDX_W  = byp_pkg::DEF_IDX_W
) (
    input  logic [IDX_W-1:0]  src_a_idx,
    input  logic              src_a_used,
    input  logic [DATA_W-1:0] rf_a_data,
    input  logic [IDX_W-1:0]  src_b_idx,
    input  logic              src_b_used,
    input  logic [DATA_W-1:0] rf_b_data,
    input  logic [IDX_W-1:0]  exm_dst,
    input  logic              exm_wen,
    input  logic              exm_is_load,
    input  logic [DATA_W-1:0] exm_result,
    input  logic [IDX_W-1:0]  mwb_dst,
    input  logic              mwb_wen,
    input  logic [DATA_W-1:0] mwb_data,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b
);
    import byp_pkg::*;

    localparam int NUM_SRC = 2;

    logic [IDX_W-1:0]  src_idx [NUM_SRC];
    logic              src_use [NUM_SRC];
    logic [DATA_W-1:0] rf_val  [NUM_SRC];
    logic [DATA_W-1:0] out_val [NUM_SRC];
    opnd_sel_e         sel     [NUM_SRC];

    assign src_idx[0] = src_a_idx;
    assign src_idx[1] = src_b_idx;
    assign src_use[0] = src_a_used;
    assign src_use[1] = src_b_used;
    assign rf_val[0]  = rf_a_data;
    assign rf_val[1]  = rf_b_data;

    generate
        for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
            logic exm_hit;
            logic mwb_hit;

            byp_hit_detect #(.IDX_W(IDX_W), .BLOCK_LOADS(1'b1)) u_exm_hit (
                .src_idx     (src_idx[k]),
                .src_used    (src_use[k]),
                .dst_idx     (exm_dst),
                .dst_wen     (exm_wen),
                .dst_is_load (exm_is_load),
                .hit         (exm_hit)
            );

            byp_hit_detect #(.IDX_W(IDX_W), .BLOCK_LOADS(1'b0)) u_mwb_hit (
                .src_idx     (src_idx[k]),
                .src_used    (src_use[k]),
                .dst_idx     (mwb_dst),
                .dst_wen     (mwb_wen),
                .dst_is_load (1'b0),
                .hit         (mwb_hit)
            );

            byp_priority u_prio (
                .exm_hit (exm_hit),
                .mwb_hit (mwb_hit),
                .sel     (sel[k])
            );

            byp_data_mux #(.DATA_W(DATA_W)) u_mux (
                .sel     (sel[k]),
                .rf_val  (rf_val[k]),
                .exr_val (exm_result),
                .mem_val (mwb_data),
                .out_val (out_val[k])
            );

            always_comb begin
                // R8
                unused_src_chk: assert (src_use[k] || sel[k] == SEL_RF);
                // R7
                load_exr_chk: assert (!(exm_is_load && sel[k] == SEL_EXR));
                // R1
                rf_pass_chk: assert (sel[k] != SEL_RF || out_val[k] == rf_val[k]);
            end
        end
    endgenerate

    assign opnd_a = out_val[0];
    assign opnd_b = out_val[1];
    assign sel_a  = sel[0];
    assign sel_b  = sel[1];

endmodule

// File: tb/tb_operand_bypass_unit.sv
module tb_operand_bypass_unit;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [4:0]  src_a_idx, src_b_idx, exm_dst, mwb_dst;
    logic        src_a_used, src_b_used, exm_wen, exm_is_load, mwb_wen;
    logic [31:0] rf_a_data, rf_b_data, exm_result, mwb_data;
    logic [31:0] opnd_a, opnd_b;
    logic [1:0]  sel_a, sel_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    operand_bypass_unit dut (
        .src_a_idx(src_a_idx), .src_a_used(src_a_used), .rf_a_data(rf_a_data),
        .src_b_idx(src_b_idx), .src_b_used(src_b_used), .rf_b_data(rf_b_data),
        .exm_dst(exm_dst), .exm_wen(exm_wen), .exm_is_load(exm_is_load),
        .exm_result(exm_result), .mwb_dst(mwb_dst), .mwb_wen(mwb_wen),
        .mwb_data(mwb_data), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .sel_a(sel_a), .sel_b(sel_b)
    );

    function automatic logic [1:0] exp_sel(input logic [4:0] s, input logic u);
        logic ex_ok, mw_ok;
        ex_ok = u && exm_wen && !exm_is_load && exm_dst != 0 && exm_dst == s;
        mw_ok = u && mwb_wen && mwb_dst != 0 && mwb_dst == s;
        if (ex_ok)      return 2'b01;
        else if (mw_ok) return 2'b10;
        else            return 2'b00;
    endfunction

    function automatic logic [31:0] exp_val(input logic [1:0] sl, input logic [31:0] rf);
        case (sl)
            2'b01:   return exm_result;
            2'b10:   return mwb_data;
            default: return rf;
        endcase
    endfunction

    task automatic check_op(input string tag, input string nm, input logic [1:0] got_s,
                            input logic [31:0] got_v, input logic [1:0] es,
                            input logic [31:0] ev);
        checks++;
        if (got_s !== es || got_v !== ev) begin
            fails++;
            $display("FAIL %s operand %s: sel=%0b val=%h expected sel=%0b val=%h",
                     tag, nm, got_s, got_v, es, ev);
        end
    endtask

    task automatic check_all(input string tag);
        logic [1:0] ea, eb;
        #1;
        ea = exp_sel(src_a_idx, src_a_used);
        eb = exp_sel(src_b_idx, src_b_used);
        check_op(tag, "A", sel_a, opnd_a, ea, exp_val(ea, rf_a_data));
        check_op(tag, "B", sel_b, opnd_b, eb, exp_val(eb, rf_b_data));
        checks++;
        if (sel_a == 2'b11 || sel_b == 2'b11) begin
            fails++;
            $display("FAIL R10: sel_a=%0b sel_b=%0b expected neither 11", sel_a, sel_b);
        end
    endtask

    task automatic drive(input logic [4:0] sa, input logic ua, input logic [4:0] sb,
                         input logic ub, input logic [4:0] ed, input logic ew,
                         input logic el, input logic [4:0] md, input logic mw);
        @(negedge clk);
        src_a_idx = sa; src_a_used = ua; src_b_idx = sb; src_b_used = ub;
        exm_dst = ed; exm_wen = ew; exm_is_load = el;
        mwb_dst = md; mwb_wen = mw;
        rf_a_data = $urandom; rf_b_data = $urandom;
        exm_result = $urandom; mwb_data = $urandom;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        // R1 idle: no producer writes
        drive(5'd3, 1, 5'd4, 1, 5'd0, 0, 0, 5'd0, 0); check_all("R1");
        // R1 names differ
        drive(5'd3, 1, 5'd4, 1, 5'd7, 1, 0, 5'd8, 1); check_all("R1");
        // R2 execute-side match on A
        drive(5'd9, 1, 5'd4, 1, 5'd9, 1, 0, 5'd2, 1); check_all("R2");
        // R3 memory-side match on B
        drive(5'd3, 1, 5'd6, 1, 5'd1, 1, 0, 5'd6, 1); check_all("R3");
        // R4 both match, execute wins
        drive(5'd5, 1, 5'd5, 1, 5'd5, 1, 0, 5'd5, 1); check_all("R4");
        // R5 write enables low
        drive(5'd5, 1, 5'd6, 1, 5'd5, 0, 0, 5'd6, 0); check_all("R5");
        // R6 register 0 on both sides
        drive(5'd0, 1, 5'd0, 1, 5'd0, 1, 0, 5'd0, 1); check_all("R6");
        // R7 load on execute side, no memory match
        drive(5'd12, 1, 5'd12, 1, 5'd12, 1, 1, 5'd3, 1); check_all("R7");
        // R7 load on execute side, memory side matches
        drive(5'd12, 1, 5'd4, 1, 5'd12, 1, 1, 5'd12, 1); check_all("R7");
        // R8 unused sources
        drive(5'd7, 0, 5'd7, 0, 5'd7, 1, 0, 5'd7, 1); check_all("R8");
        // R9 independent operands
        drive(5'd10, 1, 5'd11, 1, 5'd10, 1, 0, 5'd11, 1); check_all("R9");
        drive(5'd10, 1, 5'd10, 0, 5'd10, 1, 0, 5'd10, 1); check_all("R9");
        // Random mix over a small name set (R1 to R10)
        for (int i = 0; i < 3000; i++) begin
            drive($urandom % 4, $urandom % 4 != 0, $urandom % 4, $urandom % 4 != 0,
                  $urandom % 4, $urandom % 3 != 0, $urandom % 4 == 0,
                  $urandom % 4, $urandom % 3 != 0);
            check_all("R9 random");
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule